// File: doc/BRIEF.md
# Torus Column-Exclusive Slot Scheduler

This block decides, once per clock, which of a set of source nodes may inject a small event fragment into a two-dimensional torus of compute nodes. Each source holds a request together with the destination coordinate (column, row) of its fragment. A free-running slot counter rotates a column permission over the sources: in slot `t`, source `s` may only reach column `(s + t) mod COLS`. A source whose destination column differs from its permission waits until its slot comes round. When several sources share a permission they belong to the same group (`s mod COLS`), and one of them is picked by a priority that also rotates with the slot. No two grants in one slot can target the same torus column.

Every granted source also receives a routing header. The header holds two signed hop counts. The packet first uses the column count `dx` and then the row count `dy`. Each count takes the shorter way around its ring. Source `s` is attached to the torus at column `s mod COLS`, row `(s / COLS) mod ROWS`. A new decision is registered every cycle with no idle slot.

Top module: `column_slot_shaper`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `grant` is all zero, every hop count is zero and `grantSlot` is 0. The first decision after reset uses slot 0.
- R2: The slot number steps by one every clock and wraps from NUM_SRC-1 to 0. `grantSlot` gives the slot of the decision currently shown on `grant`.
- R3: A source is granted in slot `t` only if its request is high and its destination column equals `(s + t) mod COLS`.
- R4: Sources `g, g+COLS, g+2*COLS, ...` form group `g`, where member `m` is source `g + m*COLS`. In slot `t` the matching member first in cyclic order from member `(t / COLS) mod (NUM_SRC/COLS)` is granted. The other members of the group are not granted.
- R5: Within one slot no two granted sources share a destination column.
- R6: `hopX` for a granted source is `((destCol - s mod COLS) mod COLS)`, reduced by COLS when it exceeds COLS/2. A tie of exactly COLS/2 stays positive. The field is two's complement, COL_W+1 bits per source, with source `s` at bits `[s*(COL_W+1) +: COL_W+1]`.
- R7: `hopY` follows the same rule as R6 with ROWS and the source row `(s / COLS) mod ROWS`, using ROW_W+1 bits per source.
- R8: The hop counts of a source that is not granted in a slot are zero.
- R9: A decision is taken on the inputs present at a clock edge and is shown on the outputs right after that edge, for one cycle.
- R10: A source that keeps its request and destination steady is granted within NUM_SRC slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | NUM_SRC | Per-source request |
| destX | input | NUM_SRC*COL_W | Per-source destination column, source s at bits [s*COL_W +: COL_W] |
| destY | input | NUM_SRC*ROW_W | Per-source destination row, source s at bits [s*ROW_W +: ROW_W] |
| grant | output | NUM_SRC | Per-source grant for the current slot |
| hopX | output | NUM_SRC*(COL_W+1) | Signed column hop count per source |
| hopY | output | NUM_SRC*(ROW_W+1) | Signed row hop count per source |
| grantSlot | output | SLOT_W | Slot number of the shown decision |

## Verification
A slot counter that has drifted or stalled shifts every permission at once. The first cycle after the fault then shows grants to sources whose destination column does not fit the reported slot, and `grantSlot` is off its expected sequence. A wrong group priority shows as the wrong member granted within a group. This appears within NUM_SRC slots, as soon as two members contend. A wrong hop header appears on the same cycle as the grant it belongs to. The bench sweeps every destination for every source and adds a run in which all sources contend for one column, so each of these faults shows at the ports within a few slots.

// File: rtl/shaper_pkg.sv
package shaper_pkg;

  // Strobes from the slot control to the decision datapath.
  typedef struct packed {
    logic capture;  // take a decision at this edge
    logic wrap;     // current slot is the last one of the rotation
  } slotStrobe_t;

  // Signed shorter-way hop count on a ring of the given size.
  function automatic int ringHop(input int target, input int origin, input int size);
    int raw;
    raw = (target - origin + size) % size;
    if (raw > size / 2) raw = raw - size;
    return raw;
  endfunction

endpackage

// File: rtl/shaper_ctrl.sv
module shaper_ctrl
  import shaper_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int COLS    = 8
) (
  input  logic                clk,
  input  logic                rst,
  output slotStrobe_t         stb,
  output logic [$clog2(COLS)-1:0] baseCol,
  output logic [((NUM_SRC/COLS) > 1 ? $clog2(NUM_SRC/COLS) : 1)-1:0] leadMember,
  output logic [$clog2(NUM_SRC)-1:0] slotNow
);
  localparam int MEMBERS = NUM_SRC / COLS;
  localparam int COL_W   = $clog2(COLS);
  localparam int MEM_W   = MEMBERS > 1 ? $clog2(MEMBERS) : 1;
  localparam int SLOT_W  = $clog2(NUM_SRC);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SRC - 1);

  logic [SLOT_W-1:0] slotQ;

  always_ff @(posedge clk) begin
    if (rst)                    slotQ <= '0;
    else if (slotQ == LAST_SLOT) slotQ <= '0;
    else                        slotQ <= slotQ + 1'b1;
  end

  assign slotNow    = slotQ;
  assign baseCol    = COL_W'(int'(slotQ) % COLS);
  assign leadMember = MEM_W'((int'(slotQ) / COLS) % MEMBERS);
  assign stb.capture = !rst;
  assign stb.wrap    = (slotQ == LAST_SLOT);

  // R2: after the last slot the rotation restarts at slot 0
  a_r2_wrap_restart: assert property (@(posedge clk) disable iff (rst)
    stb.wrap |=> (slotNow == '0 && baseCol == '0));

  // R4: group priority only moves when the column rotation completes
  a_r4_lead_steady: assert property (@(posedge clk) disable iff (rst)
    (baseCol != COL_W'(COLS - 1)) |=> $stable(leadMember));

endmodule

// File: rtl/shaper_path.sv
module shaper_path
  import shaper_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int COLS    = 8,
  parameter int ROWS    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  slotStrobe_t         stb,
  input  logic [$clog2(COLS)-1:0] baseCol,
  input  logic [((NUM_SRC/COLS) > 1 ? $clog2(NUM_SRC/COLS) : 1)-1:0] leadMember,
  input  logic [$clog2(NUM_SRC)-1:0] slotNow,
  input  logic [NUM_SRC-1:0]  req,
  input  logic [NUM_SRC*$clog2(COLS)-1:0] destX,
  input  logic [NUM_SRC*$clog2(ROWS)-1:0] destY,
  output logic [NUM_SRC-1:0]  grant,
  output logic [NUM_SRC*($clog2(COLS)+1)-1:0] hopX,
  output logic [NUM_SRC*($clog2(ROWS)+1)-1:0] hopY,
  output logic [$clog2(NUM_SRC)-1:0] grantSlot
);
  localparam int MEMBERS = NUM_SRC / COLS;
  localparam int COL_W   = $clog2(COLS);
  localparam int ROW_W   = $clog2(ROWS);
  localparam int HX_W    = COL_W + 1;
  localparam int HY_W    = ROW_W + 1;
  localparam int SLOT_W  = $clog2(NUM_SRC);

  logic [COL_W-1:0] dX      [NUM_SRC];
  logic [ROW_W-1:0] dY      [NUM_SRC];
  logic [COL_W-1:0] permCol [NUM_SRC];
  logic [HX_W-1:0]  hxNext  [NUM_SRC];
  logic [HY_W-1:0]  hyNext  [NUM_SRC];
  logic [NUM_SRC-1:0] match;
  logic [NUM_SRC-1:0] winNext;

  logic [NUM_SRC-1:0][HX_W-1:0] hxQ;
  logic [NUM_SRC-1:0][HY_W-1:0] hyQ;
  logic [NUM_SRC-1:0]           grantQ;
  logic [SLOT_W-1:0]            slotQ;

  // Per-source permission match and header arithmetic
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    localparam int SX = s % COLS;
    localparam int SY = (s / COLS) % ROWS;
    assign dX[s]      = destX[s*COL_W +: COL_W];
    assign dY[s]      = destY[s*ROW_W +: ROW_W];
    assign permCol[s] = COL_W'((SX + int'(baseCol)) % COLS);
    assign match[s]   = req[s] && (dX[s] == permCol[s]);
    assign hxNext[s]  = HX_W'(ringHop(int'(dX[s]), SX, COLS));
    assign hyNext[s]  = HY_W'(ringHop(int'(dY[s]), SY, ROWS));
  end

  // One winner per group, priority rotating from leadMember
  always_comb begin
    logic found;
    int   mem;
    winNext = '0;
    for (int g = 0; g < COLS; g++) begin
      found = 1'b0;
      for (int k = 0; k < MEMBERS; k++) begin
        mem = (int'(leadMember) + k) % MEMBERS;
        if (!found && match[g + mem*COLS]) begin
          winNext[g + mem*COLS] = 1'b1;
          found = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grantQ <= '0;
      hxQ    <= '0;
      hyQ    <= '0;
      slotQ  <= '0;
    end else if (stb.capture) begin
      grantQ <= winNext;
      slotQ  <= slotNow;
      for (int s = 0; s < NUM_SRC; s++) begin
        hxQ[s] <= winNext[s] ? hxNext[s] : '0;
        hyQ[s] <= winNext[s] ? hyNext[s] : '0;
      end
    end
  end

  assign grant     = grantQ;
  assign hopX      = hxQ;
  assign hopY      = hyQ;
  assign grantSlot = slotQ;

  // R5: winners of one decision never share a destination column
  for (genvar c = 0; c < COLS; c++) begin : g_colchk
    logic [NUM_SRC-1:0] colHit;
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_hit
      assign colHit[s] = winNext[s] && (dX[s] == COL_W'(c));
    end
    a_r5_col_exclusive: assert property (@(posedge clk) disable iff (rst)
      $onehot0(colHit));
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_srcchk
    // R3: a shown grant matched the permission of the slot it was taken in
    a_r3_perm_match: assert property (@(posedge clk) disable iff (rst)
      grant[s] |-> ($past(dX[s]) == $past(permCol[s]) && $past(req[s])));
    // R8: idle sources carry zero headers
    a_r8_idle_header: assert property (@(posedge clk) disable iff (rst)
      !grant[s] |-> (hxQ[s] == '0 && hyQ[s] == '0));
  end

  for (genvar g = 0; g < COLS; g++) begin : g_grpchk
    logic [MEMBERS-1:0] grpGrant;
    for (genvar m = 0; m < MEMBERS; m++) begin : g_mem
      assign grpGrant[m] = grant[g + m*COLS];
    end
    // R4: at most one member of a group holds a grant
    a_r4_group_single: assert property (@(posedge clk) disable iff (rst)
      $onehot0(grpGrant));
  end

endmodule

// File: rtl/column_slot_shaper.sv
module column_slot_shaper
  import shaper_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int COLS    = 8,
  parameter int ROWS    = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic [NUM_SRC-1:0] req,
  input  logic [NUM_SRC*$clog2(COLS)-1:0] destX,
  input  logic [NUM_SRC*$clog2(ROWS)-1:0] destY,
  output logic [NUM_SRC-1:0] grant,
  output logic [NUM_SRC*($clog2(COLS)+1)-1:0] hopX,
  output logic [NUM_SRC*($clog2(ROWS)+1)-1:0] hopY,
  output logic [$clog2(NUM_SRC)-1:0] grantSlot
);
  localparam int MEMBERS = NUM_SRC / COLS;
  localparam int COL_W   = $clog2(COLS);
  localparam int MEM_W   = MEMBERS > 1 ? $clog2(MEMBERS) : 1;
  localparam int SLOT_W  = $clog2(NUM_SRC);

  slotStrobe_t       stb;
  logic [COL_W-1:0]  baseCol;
  logic [MEM_W-1:0]  leadMember;
  logic [SLOT_W-1:0] slotNow;

  shaper_ctrl #(.NUM_SRC(NUM_SRC), .COLS(COLS)) u_ctrl (
    .clk(clk), .rst(rst), .stb(stb), .baseCol(baseCol),
    .leadMember(leadMember), .slotNow(slotNow)
  );

  shaper_path #(.NUM_SRC(NUM_SRC), .COLS(COLS), .ROWS(ROWS)) u_path (
    .clk(clk), .rst(rst), .stb(stb), .baseCol(baseCol),
    .leadMember(leadMember), .slotNow(slotNow),
    .req(req), .destX(destX), .destY(destY),
    .grant(grant), .hopX(hopX), .hopY(hopY), .grantSlot(grantSlot)
  );

endmodule

// File: tb/column_slot_shaper_bench.sv
module column_slot_shaper_bench;
  localparam int NS  = 32;
  localparam int NC  = 8;
  localparam int NR  = 8;
  localparam int CW  = 3;
  localparam int RW  = 3;
  localparam int HXW = CW + 1;
  localparam int HYW = RW + 1;
  localparam int SW  = 5;
  localparam int NM  = NS / NC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NS-1:0]      req = '0;
  logic [NS*CW-1:0]   destX = '0;
  logic [NS*RW-1:0]   destY = '0;
  logic [NS-1:0]      grant;
  logic [NS*HXW-1:0]  hopX;
  logic [NS*HYW-1:0]  hopY;
  logic [SW-1:0]      grantSlot;

  always #2.5 clk = ~clk;

  column_slot_shaper #(.NUM_SRC(NS), .COLS(NC), .ROWS(NR)) u_column_slot_shaper (
    .clk(clk), .rst(rst), .req(req), .destX(destX), .destY(destY),
    .grant(grant), .hopX(hopX), .hopY(hopY), .grantSlot(grantSlot)
  );

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  int pend [NS];
  int pdx  [NS];
  int pdy  [NS];
  int done [NS];
  int waitN[NS];
  bit expGrant [NS];
  int expSlot;
  bit expValid;
  int bslot;

  function automatic int hop(input int tgt, input int org, input int size);
    int r;
    r = (tgt - org + size) % size;
    if (r > size / 2) r = r - size;
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkIdle(input string tag);
    chk(grant == '0, tag, int'(grant), 0);
    chk(hopX == '0 && hopY == '0, tag, int'(hopX != '0 || hopY != '0), 0);
    chk(grantSlot == '0, tag, int'(grantSlot), 0);
  endtask

  // R1: reset clears outputs and restarts the slot rotation
  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    req = '0;
    @(negedge clk);
    @(negedge clk);
    checkIdle("R1 in reset");
    rst = 1'b0;
    bslot = 0;
    expValid = 0;
    for (int s = 0; s < NS; s++) begin pend[s] = 0; done[s] = 0; waitN[s] = 0; end
  endtask

  task automatic checkOutputs();
    int expAct, cnt, dxA, dyA, zeroOk;
    int colCnt [NC];
    zeroOk = 1;
    for (int c = 0; c < NC; c++) colCnt[c] = 0;
    for (int s = 0; s < NS; s++) begin
      if (grant[s] !== expGrant[s]) begin
        chk(0, $sformatf("R3/R4/R9 grant src %0d slot %0d", s, expSlot), int'(grant[s]), int'(expGrant[s]));
      end
      if (grant[s]) colCnt[pdx[s]]++;
      if (expGrant[s] && grant[s]) begin
        dxA = $signed(hopX[s*HXW +: HXW]);
        dyA = $signed(hopY[s*HYW +: HYW]);
        expAct = hop(pdx[s], s % NC, NC);
        chk(dxA == expAct, $sformatf("R6 hopX src %0d", s), dxA, expAct);
        expAct = hop(pdy[s], (s / NC) % NR, NR);
        chk(dyA == expAct, $sformatf("R7 hopY src %0d", s), dyA, expAct);
      end else if (!grant[s]) begin
        if (hopX[s*HXW +: HXW] != '0 || hopY[s*HYW +: HYW] != '0) zeroOk = 0;
      end
    end
    total++;  // R3/R4/R9: whole-vector grant check
    chk(zeroOk == 1, "R8 idle header zero", zeroOk, 1);
    cnt = 0;
    for (int c = 0; c < NC; c++) if (colCnt[c] > 1) cnt++;
    chk(cnt == 0, "R5 column shared", cnt, 0);
    chk(int'(grantSlot) == expSlot, "R2 grantSlot", int'(grantSlot), expSlot);
  endtask

  // mode 0: every destination per source; 1: all on one column; 2: mixed walk
  task automatic runPhase(input int mode, input int quota);
    int cyc, lead, mem, src;
    bit found, allDone;
    cyc = 0;
    forever begin
      if (expValid) begin
        checkOutputs();
        for (int s = 0; s < NS; s++) begin
          if (expGrant[s]) begin
            chk(waitN[s] <= NS, $sformatf("R10 wait src %0d", s), waitN[s], NS);
            pend[s] = 0;
            done[s]++;
          end
        end
      end
      allDone = 1;
      for (int s = 0; s < NS; s++) if (done[s] < quota) allDone = 0;
      if (allDone) break;
      if (cyc > 20000) begin
        chk(0, "R10 phase watchdog", cyc, 20000);
        break;
      end
      for (int s = 0; s < NS; s++) begin
        if (!pend[s] && done[s] < quota) begin
          pend[s] = 1;
          waitN[s] = 0;
          case (mode)
            0: begin pdx[s] = done[s] % NC; pdy[s] = (done[s] / NC) % NR; end
            1: begin pdx[s] = 3; pdy[s] = s % NR; end
            default: begin pdx[s] = (s * 5 + done[s] * 3) % NC; pdy[s] = (s + done[s] * 7) % NR; end
          endcase
        end
        req[s] = (pend[s] != 0);
        destX[s*CW +: CW] = CW'(pdx[s]);
        destY[s*RW +: RW] = RW'(pdy[s]);
      end
      lead = (bslot / NC) % NM;
      for (int s = 0; s < NS; s++) expGrant[s] = 0;
      for (int g = 0; g < NC; g++) begin
        found = 0;
        for (int k = 0; k < NM; k++) begin
          mem = (lead + k) % NM;
          src = g + mem * NC;
          if (!found && pend[src] != 0 && pdx[src] == (src + bslot) % NC) begin
            expGrant[src] = 1;
            found = 1;
          end
        end
      end
      for (int s = 0; s < NS; s++) if (pend[s] != 0) waitN[s]++;
      expSlot = bslot;
      bslot = (bslot + 1) % NS;
      expValid = 1;
      cyc++;
      @(negedge clk);
    end
    req = '0;
    expValid = 0;
  endtask

  initial begin
    doReset();
    @(negedge clk);
    checkIdle("R1 after release no request");
    bslot = 1;
    runPhase(0, NC * NR);
    doReset();
    runPhase(1, 1);
    doReset();
    runPhase(2, 40);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule